// File: doc/BRIEF.md
# Clock-Group Valid Reset Watchdog

This block produces the reset for a source-synchronous capture FIFO that gathers the valid flags of one clock group. It offers two modes, and a configuration bit selects one of them. In timeout mode an 8-bit counter starts from a programmable preset and counts timebase ticks. Any enabled edge on the capture clocks reloads the counter. If no enabled edge arrives before the counter wraps past its maximum, the block emits a one-cycle reset pulse. In direct mode the counter is ignored, and the reset follows the level of one selected capture clock compared against a programmable polarity.

The timebase is either every system clock cycle or a heartbeat strobe supplied from outside. The capture clocks arrive as sampled levels. Every clock has its own rising-edge enable and its own falling-edge enable. The block also drives the depth that the FIFO must use. That depth is four stages in the low rate band and three stages in the high band.

Configuration is loaded through a write strobe. A write is accepted only while acquisition is idle. While acquisition is idle the block never asserts reset and holds the counter at its preset.

Top module: `cgv_rst_wdog`

## Requirements
- R1: In timeout mode during acquisition, the counter loaded with preset P counts one step per timebase tick. The reset pulse appears one cycle after the tick that finds the counter at 255, which is the (256-P)-th tick after the load.
- R2: Channel i reloads the counter to the preset on a rising edge when rise-enable bit i is 1, and on a falling edge when fall-enable bit i is 1. An edge whose enable bit is 0 has no effect.
- R3: An enabled edge in the same cycle as the wrapping tick suppresses that reset pulse, and the counter restarts from the preset.
- R4: When the timebase bit is 0, every clock cycle is a tick. When it is 1, only cycles with `hb_tick_i` high are ticks.
- R5: In timeout mode each reset pulse lasts exactly one cycle, provided the preset is not 255. After a wrap the counter restarts at the preset, so pulses repeat every 256-P ticks.
- R6: When the mode bit is 1 (direct mode) during acquisition, `fifo_rst_o` equals (capture clock `cfg_src_i` == `cfg_pol_i`) one cycle later. Capture edges and the counter have no effect in this mode.
- R7: While `acq_active_i` is 0, `fifo_rst_o` is 0 from the next cycle on.
- R8: `depth_o` is 4 when the rate-band bit is 0 and 3 when it is 1. After reset every configuration field is 0: timeout mode, every-cycle timebase, preset 0, edges disabled, depth 4, and `fifo_rst_o` low.
- R9: A configuration write while `acq_active_i` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acq_active_i | input | 1 | Acquisition running |
| hb_tick_i | input | 1 | Heartbeat timebase strobe |
| cap_clk_i | input | N_CLK | Sampled capture clock levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 1 | 0 timeout mode, 1 direct mode |
| cfg_tbsel_i | input | 1 | 0 every cycle, 1 heartbeat |
| cfg_preset_i | input | CNT_W | Counter preset |
| cfg_src_i | input | SEL_W | Capture clock used in direct mode |
| cfg_pol_i | input | 1 | Level that asserts reset in direct mode |
| cfg_rise_en_i | input | N_CLK | Per-clock rising-edge enables |
| cfg_fall_en_i | input | N_CLK | Per-clock falling-edge enables |
| cfg_rate_hi_i | input | 1 | Rate band above threshold |
| fifo_rst_o | output | 1 | FIFO reset, registered |
| depth_o | output | DEPTH_W | FIFO stage count |

## Verification
The assertions check on every cycle the relations that hold between neighbouring cycles:
- An enabled edge reloads the counter and blocks the next pulse.
- A tick at the maximum count produces a pulse.
- A timeout-mode pulse never lasts two cycles.
- Idle cycles keep the reset low.
- Direct mode follows the selected clock.
- The depth output always holds one of its two legal values.

Other properties depend on history and can only be shown by the bench scenarios: the exact spacing of 256-P ticks, the counting of heartbeat ticks only, and the rejection of a write made while acquisition is active.

// File: rtl/cgv_pkg.sv
package cgv_pkg;
   typedef enum logic {
      CGV_TIMEOUT = 1'b0,
      CGV_DIRECT  = 1'b1
   } cgv_mode_e;

   typedef enum logic {
      CGV_TB_FAST  = 1'b0,
      CGV_TB_HEART = 1'b1
   } cgv_tb_e;
endpackage

// File: rtl/cgv_cfg_regs.sv
module cgv_cfg_regs
   import cgv_pkg::*;
#(
   parameter int N_CLK = 4,
   parameter int CNT_W = 8,
   parameter int SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             acq_active_i,
   input  logic             we_i,
   input  logic             mode_i,
   input  logic             tbsel_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic [SEL_W-1:0] src_i,
   input  logic             pol_i,
   input  logic [N_CLK-1:0] rise_en_i,
   input  logic [N_CLK-1:0] fall_en_i,
   input  logic             rate_hi_i,
   output cgv_mode_e        mode_q,
   output cgv_tb_e          tb_q,
   output logic [CNT_W-1:0] preset_q,
   output logic [SEL_W-1:0] src_q,
   output logic             pol_q,
   output logic [N_CLK-1:0] rise_en_q,
   output logic [N_CLK-1:0] fall_en_q,
   output logic             rate_hi_q
);
   // Writes are accepted only while acquisition is idle.
   logic wr_ok;
   assign wr_ok = we_i & ~acq_active_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q    <= CGV_TIMEOUT;
         tb_q      <= CGV_TB_FAST;
         preset_q  <= '0;
         src_q     <= '0;
         pol_q     <= 1'b0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         rate_hi_q <= 1'b0;
      end else if (wr_ok) begin
         mode_q    <= cgv_mode_e'(mode_i);
         tb_q      <= cgv_tb_e'(tbsel_i);
         preset_q  <= preset_i;
         src_q     <= src_i;
         pol_q     <= pol_i;
         rise_en_q <= rise_en_i;
         fall_en_q <= fall_en_i;
         rate_hi_q <= rate_hi_i;
      end
   end
endmodule

// File: rtl/cgv_edge_det.sv
module cgv_edge_det #(
   parameter int N_CLK = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_CLK-1:0] cap_i,
   input  logic [N_CLK-1:0] rise_en_i,
   input  logic [N_CLK-1:0] fall_en_i,
   output logic             edge_o
);
   logic [N_CLK-1:0] prev_q;
   logic [N_CLK-1:0] hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= cap_i;
   end

   for (genvar i = 0; i < N_CLK; i++) begin : g_lane
      assign hit[i] = (rise_en_i[i] &  cap_i[i] & ~prev_q[i])
                    | (fall_en_i[i] & ~cap_i[i] &  prev_q[i]);
   end

   assign edge_o = |hit;
endmodule

// File: rtl/cgv_timeout_ctr.sv
module cgv_timeout_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] preset_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   // Held at the preset while stopped, reloaded by an edge, and
   // restarted from the preset after the count wraps.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (!run_i || reload_i) begin
         cnt_o <= preset_i;
      end else if (tick_i) begin
         if (cnt_o == CNT_MAX) cnt_o <= preset_i;
         else                  cnt_o <= cnt_o + CNT_ONE;
      end
   end
endmodule

// File: rtl/cgv_rst_wdog.sv
module cgv_rst_wdog
   import cgv_pkg::*;
#(
   parameter int N_CLK      = 4,
   parameter int CNT_W      = 8,
   parameter int SEL_W      = $clog2(N_CLK),
   parameter int DEPTH_W    = 3,
   parameter int DEPTH_SLOW = 4,
   parameter int DEPTH_FAST = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               acq_active_i,
   input  logic               hb_tick_i,
   input  logic [N_CLK-1:0]   cap_clk_i,
   input  logic               cfg_we_i,
   input  logic               cfg_mode_i,
   input  logic               cfg_tbsel_i,
   input  logic [CNT_W-1:0]   cfg_preset_i,
   input  logic [SEL_W-1:0]   cfg_src_i,
   input  logic               cfg_pol_i,
   input  logic [N_CLK-1:0]   cfg_rise_en_i,
   input  logic [N_CLK-1:0]   cfg_fall_en_i,
   input  logic               cfg_rate_hi_i,
   output logic               fifo_rst_o,
   output logic [DEPTH_W-1:0] depth_o
);
   localparam logic [CNT_W-1:0]   CNT_MAX = '1;
   localparam logic [DEPTH_W-1:0] D_SLOW  = DEPTH_W'(DEPTH_SLOW);
   localparam logic [DEPTH_W-1:0] D_FAST  = DEPTH_W'(DEPTH_FAST);

   // Elaboration-time parameter checks
   if (N_CLK < 2) begin : g_chk_nclk
      $error("cgv_rst_wdog: N_CLK must be at least 2");
   end
   if (SEL_W != $clog2(N_CLK)) begin : g_chk_sel
      $error("cgv_rst_wdog: SEL_W must equal clog2(N_CLK)");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("cgv_rst_wdog: CNT_W must be at least 2");
   end
   if (DEPTH_SLOW >= (1 << DEPTH_W) || DEPTH_FAST >= (1 << DEPTH_W)
       || DEPTH_FAST < 1 || DEPTH_SLOW < 1) begin : g_chk_depth
      $error("cgv_rst_wdog: depths must fit DEPTH_W and be nonzero");
   end

   cgv_mode_e        mode_q;
   cgv_tb_e          tb_q;
   logic [CNT_W-1:0] preset_q;
   logic [SEL_W-1:0] src_q;
   logic             pol_q;
   logic [N_CLK-1:0] rise_en_q;
   logic [N_CLK-1:0] fall_en_q;
   logic             rate_hi_q;

   cgv_cfg_regs #(
      .N_CLK (N_CLK),
      .CNT_W (CNT_W),
      .SEL_W (SEL_W)
   ) u_cfg (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .acq_active_i (acq_active_i),
      .we_i         (cfg_we_i),
      .mode_i       (cfg_mode_i),
      .tbsel_i      (cfg_tbsel_i),
      .preset_i     (cfg_preset_i),
      .src_i        (cfg_src_i),
      .pol_i        (cfg_pol_i),
      .rise_en_i    (cfg_rise_en_i),
      .fall_en_i    (cfg_fall_en_i),
      .rate_hi_i    (cfg_rate_hi_i),
      .mode_q       (mode_q),
      .tb_q         (tb_q),
      .preset_q     (preset_q),
      .src_q        (src_q),
      .pol_q        (pol_q),
      .rise_en_q    (rise_en_q),
      .fall_en_q    (fall_en_q),
      .rate_hi_q    (rate_hi_q)
   );

   logic edge_any;

   cgv_edge_det #(
      .N_CLK (N_CLK)
   ) u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (cap_clk_i),
      .rise_en_i (rise_en_q),
      .fall_en_i (fall_en_q),
      .edge_o    (edge_any)
   );

   logic             tick_en;
   logic             run;
   logic [CNT_W-1:0] cnt_q;

   assign tick_en = (tb_q == CGV_TB_HEART) ? hb_tick_i : 1'b1;
   assign run     = acq_active_i && (mode_q == CGV_TIMEOUT);

   cgv_timeout_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .tick_i   (tick_en),
      .reload_i (edge_any),
      .preset_i (preset_q),
      .cnt_o    (cnt_q)
   );

   // A wrap raises the reset unless an enabled edge in the same cycle
   // clears it first.
   logic expire;
   logic sel_lvl;
   logic rst_d;

   assign expire  = run & tick_en & ~edge_any & (cnt_q == CNT_MAX);
   assign sel_lvl = cap_clk_i[src_q];

   always_comb begin
      rst_d = 1'b0;
      if (acq_active_i) begin
         if (mode_q == CGV_DIRECT) rst_d = (sel_lvl == pol_q);
         else                      rst_d = expire;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) fifo_rst_o <= 1'b0;
      else         fifo_rst_o <= rst_d;
   end

   assign depth_o = rate_hi_q ? D_FAST : D_SLOW;
endmodule

// File: rtl/cgv_rst_wdog_chk.sv
module cgv_rst_wdog_chk
   import cgv_pkg::*;
#(
   parameter int N_CLK      = 4,
   parameter int CNT_W      = 8,
   parameter int SEL_W      = 2,
   parameter int DEPTH_W    = 3,
   parameter int DEPTH_SLOW = 4,
   parameter int DEPTH_FAST = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               acq_active_i,
   input logic [N_CLK-1:0]   cap_clk_i,
   input logic               fifo_rst_o,
   input logic [DEPTH_W-1:0] depth_o,
   input logic               mode_q,
   input logic               tick_en,
   input logic               edge_any,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [CNT_W-1:0]   preset_q,
   input logic [SEL_W-1:0]   src_q,
   input logic               pol_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic run_c;
   logic sel_match;
   assign run_c     = acq_active_i && (mode_q == CGV_TIMEOUT);
   assign sel_match = (cap_clk_i[src_q] == pol_q);

   a_r1_wrap_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_c && tick_en && !edge_any && cnt_q == CNT_MAX) |=> fifo_rst_o);

   a_r2_edge_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_c && edge_any) |=> (cnt_q == $past(preset_q)));

   a_r3_edge_blocks_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_c && edge_any) |=> !fifo_rst_o);

   a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == CGV_TIMEOUT && fifo_rst_o && preset_q != CNT_MAX) |=> !fifo_rst_o);

   a_r6_direct_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_active_i && mode_q == CGV_DIRECT) |=> (fifo_rst_o == $past(sel_match)));

   a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acq_active_i |=> !fifo_rst_o);

   a_r8_depth_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (depth_o == DEPTH_W'(DEPTH_SLOW)) || (depth_o == DEPTH_W'(DEPTH_FAST)));
endmodule

bind cgv_rst_wdog cgv_rst_wdog_chk #(
   .N_CLK      (N_CLK),
   .CNT_W      (CNT_W),
   .SEL_W      (SEL_W),
   .DEPTH_W    (DEPTH_W),
   .DEPTH_SLOW (DEPTH_SLOW),
   .DEPTH_FAST (DEPTH_FAST)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .acq_active_i (acq_active_i),
   .cap_clk_i    (cap_clk_i),
   .fifo_rst_o   (fifo_rst_o),
   .depth_o      (depth_o),
   .mode_q       (mode_q),
   .tick_en      (tick_en),
   .edge_any     (edge_any),
   .cnt_q        (cnt_q),
   .preset_q     (preset_q),
   .src_q        (src_q),
   .pol_q        (pol_q)
);

// File: tb/tb_cgv_rst_wdog.sv
module tb_cgv_rst_wdog;
   localparam int N_CLK = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acq = 1'b0;
   logic             hb = 1'b0;
   logic [N_CLK-1:0] cap = '0;
   logic             we = 1'b0;
   logic             mode = 1'b0;
   logic             tbsel = 1'b0;
   logic [7:0]       preset = '0;
   logic [1:0]       src = '0;
   logic             pol = 1'b0;
   logic [N_CLK-1:0] rise_en = '0;
   logic [N_CLK-1:0] fall_en = '0;
   logic             rate_hi = 1'b0;
   logic             fifo_rst;
   logic [2:0]       depth;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;

   int    exp_q[$];
   string exp_tag[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cgv_rst_wdog dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .acq_active_i  (acq),
      .hb_tick_i     (hb),
      .cap_clk_i     (cap),
      .cfg_we_i      (we),
      .cfg_mode_i    (mode),
      .cfg_tbsel_i   (tbsel),
      .cfg_preset_i  (preset),
      .cfg_src_i     (src),
      .cfg_pol_i     (pol),
      .cfg_rise_en_i (rise_en),
      .cfg_fall_en_i (fall_en),
      .cfg_rate_hi_i (rate_hi),
      .fifo_rst_o    (fifo_rst),
      .depth_o       (depth)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Scoreboard: the driver pushes the cycles in which the reset must be high.
   task automatic expect_rst(input int at, input string req);
      exp_q.push_back(at);
      exp_tag.push_back(req);
   endtask

   always @(negedge clk) begin
      if (mon_en && fifo_rst === 1'b1) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected reset pulse (R1 R3 R6 R7)", cyc, -1);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = exp_tag.pop_front();
            check(cyc == e, t, cyc, e);
         end
      end
   end

   task automatic drain(input string req);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
      exp_tag.delete();
   endtask

   task automatic cfg_write(input bit m, input bit tb, input int p, input int s,
                            input bit pl, input int re, input int fe, input bit rh);
      @(negedge clk);
      mode = m; tbsel = tb; preset = 8'(p); src = 2'(s); pol = pl;
      rise_en = N_CLK'(re); fall_en = N_CLK'(fe); rate_hi = rh; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(2);
      // R8: reset state
      check(fifo_rst == 1'b0, "R8 reset rst low", int'(fifo_rst), 0);
      check(depth == 3'd4, "R8 reset depth", int'(depth), 4);
      mon_en = 1'b1;

      // R1 R5: free-running timeout, P=250 gives a pulse every 6 ticks
      cfg_write(1'b0, 1'b0, 250, 0, 1'b0, 0, 0, 1'b0);
      @(negedge clk); acq = 1'b1; n = cyc;
      expect_rst(n + 6, "R1 first wrap");
      expect_rst(n + 12, "R5 periodic restart");
      wait_cycles(14); acq = 1'b0;   // R7: the pulse due at n+18 must not appear
      wait_cycles(8);
      drain("R1 R5 R7 missing pulse");

      // R2: rise on clock 0 and fall on clock 2 enabled, fall on 0 disabled
      cfg_write(1'b0, 1'b0, 250, 0, 1'b0, 4'b0001, 4'b0100, 1'b0);
      @(negedge clk); acq = 1'b1;
      for (int i = 0; i < 10; i++) begin
         wait_cycles(2);
         cap[0] = ~cap[0];
         cap[2] = ~cap[2];
      end
      n = cyc;                       // last toggle was an enabled falling edge on clock 2
      expect_rst(n + 7, "R2 reload then wrap");
      wait_cycles(9); acq = 1'b0;
      wait_cycles(4);
      drain("R2 missing pulse");

      // R3: enabled edge on the wrapping tick cancels that pulse
      @(negedge clk); acq = 1'b1; n = cyc;
      wait_cycles(5); cap[0] = 1'b1;  // seen at edge n+6, the wrap edge
      expect_rst(n + 12, "R3 cancelled then reloaded");
      wait_cycles(8); acq = 1'b0;
      cap[0] = 1'b0;
      wait_cycles(4);
      drain("R3 missing pulse");

      // R4: heartbeat timebase, P=254 needs two heartbeat ticks
      cfg_write(1'b0, 1'b1, 254, 0, 1'b0, 0, 0, 1'b0);
      @(negedge clk); acq = 1'b1; n = cyc;
      wait_cycles(2); hb = 1'b1;
      wait_cycles(1); hb = 1'b0;
      wait_cycles(2); hb = 1'b1;
      wait_cycles(1); hb = 1'b0;
      expect_rst(n + 6, "R4 heartbeat ticks only");
      wait_cycles(4); acq = 1'b0;
      wait_cycles(3);
      drain("R4 missing pulse");

      // R6: direct mode, source 2, active high; clock 0 edges are ignored
      cfg_write(1'b1, 1'b0, 250, 2, 1'b1, 4'b0001, 0, 1'b0);
      @(negedge clk); acq = 1'b1; n = cyc;
      wait_cycles(2); cap[2] = 1'b1; cap[0] = 1'b1;
      expect_rst(n + 3, "R6 follow high");
      expect_rst(n + 4, "R6 follow high");
      expect_rst(n + 5, "R6 follow high");
      wait_cycles(3); cap[2] = 1'b0; cap[0] = 1'b0;
      wait_cycles(6); acq = 1'b0;
      wait_cycles(3);
      drain("R6 missing level");

      // R6: active-low polarity
      cfg_write(1'b1, 1'b0, 250, 2, 1'b0, 0, 0, 1'b0);
      @(negedge clk); cap[2] = 1'b1;
      @(negedge clk); acq = 1'b1; n = cyc;
      wait_cycles(2); cap[2] = 1'b0;
      wait_cycles(1); cap[2] = 1'b1;
      expect_rst(n + 3, "R6 low polarity");
      wait_cycles(3); acq = 1'b0;
      wait_cycles(3);
      drain("R6 low polarity missing");

      // R9: a write during acquisition is ignored (the new fields would give
      // timeout mode with preset 0 and the high-rate depth)
      @(negedge clk); acq = 1'b1; n = cyc;
      cfg_write(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b1);
      wait_cycles(2);
      check(depth == 3'd4, "R9 depth unchanged while active", int'(depth), 4);
      wait_cycles(260);
      check(fifo_rst == 1'b0, "R9 mode unchanged while active", int'(fifo_rst), 0);
      acq = 1'b0;
      wait_cycles(2);
      drain("R9 no pulses expected");

      // R8: rate band selects three stages once written while idle
      cfg_write(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b1);
      wait_cycles(1);
      check(depth == 3'd3, "R8 high band depth", int'(depth), 3);
      cfg_write(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
      wait_cycles(1);
      check(depth == 3'd4, "R8 low band depth", int'(depth), 4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule